// File: doc/BRIEF.md
# Multi-Source XOR Zero-Check Engine

This engine confirms that a group of equal-length regions in local memory are parity-consistent. It walks the regions one 8-byte offset at a time. At each offset it fetches the 64-bit word at that offset from every active source, XORs the words together and tests all eight byte lanes of the combined word for zero. A sticky flag records whether any offset produced a non-zero combination. No result buffer is written.

A pass is configured through a set of descriptor-style inputs:
- two to four source base addresses, each with a flag that marks the source as local;
- the number of active sources;
- a byte count;
- a write-back enable.

These inputs are sampled on an accepted start pulse. Words are read through a request/response port: requests use a valid/ready handshake, and response data comes back at least one cycle later with its own valid strobe.

When every word has been consumed, the engine finishes in one of two ways. If write-back is enabled, it issues a one-cycle status write that carries the completion and not-zero bits. Otherwise, it raises an interrupt and stays suspended until an acknowledge arrives. A configuration that cannot be run is refused with an error pulse, and no memory traffic follows.

Top module: `xzc_engine`

## Requirements
- R1: At every offset the engine XORs the 64-bit words of all active sources. `res_nz` (and status bit 30) ends the pass at 1 if any offset's combined word is non-zero, and at 0 otherwise.
- R2: For an accepted pass with N sources and byte count C, the engine issues exactly N*C/8 reads. At offset k (0, 8, ..., C-8) it reads base0+k, base1+k, ..., base(N-1)+k in that order. Base addresses of sources at index N or above are never used.
- R3: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` stays stable. After a request is accepted, no new request is made until `rd_rvalid` returns the data.
- R4: A start pulse in idle is refused in any of these cases: the byte count is zero or not a multiple of 8; `num_src` is outside 2..4; or any active source (index below `num_src`) has its local flag at 0. On refusal, `cfg_err` is high for exactly the cycle after the start edge, the engine stays idle and no read is issued.
- R5: With `wb_en`=1, the pass ends with `stat_we` high for one cycle. In that cycle `stat_word[31]` (complete) is 1, `stat_word[30]` is the not-zero result and `stat_word[23:0]` is the byte count. `irq` stays low.
- R6: With `wb_en`=0, the pass ends with `irq` high and `stat_we` never pulsing. `irq` and `busy` stay high until `irq_ack` is sampled high; one edge later the engine is idle. `res_nz` holds the result while the engine is suspended.
- R7: A start pulse is ignored unless the engine is idle, whether the engine is running or suspended.
- R8: The not-zero flag is cleared by every accepted start, so a clean pass that follows a dirty pass reports 0.
- R9: Each of the eight byte lanes of the combined word is tested. A single flipped bit in any one lane of any one source makes the result not-zero.
- R10: The local flags of sources at index `num_src` or above do not affect acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only in idle |
| wb_en | input | 1 | 1: status write-back at the end of the pass; 0: interrupt and suspend |
| num_src | input | 3 | Number of active sources (2..4) |
| byte_count | input | 24 | Bytes per source region |
| src_base | input | 64 | Four 16-bit byte addresses; source i is in bits [16i+15:16i] |
| src_local | input | 4 | Per-source local-memory flag |
| irq_ack | input | 1 | Interrupt acknowledge / resume |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 16 | Byte address of the requested 64-bit word |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 64 | Read data |
| busy | output | 1 | Engine not idle |
| cfg_err | output | 1 | One-cycle pulse when a start is refused |
| stat_we | output | 1 | Status write strobe |
| stat_word | output | 32 | Status word: [31] complete, [30] not-zero, [23:0] byte count |
| irq | output | 1 | Completion interrupt, held while suspended |
| res_nz | output | 1 | Sticky not-zero result |

## Verification
Assertions check several properties on every cycle:
- the read request stays held with a stable address until it is accepted;
- the source index stays below the latched source count while the engine is busy;
- the not-zero flag stays sticky until the next accepted start;
- `cfg_err` appears only while the engine is idle;
- write-back and interrupt never coincide;
- the interrupt holds until it is acknowledged, and a start during suspension leaves the engine suspended.

Only the bench scenarios can show the following:
- the exact order and number of addresses;
- the XOR result against a computed reference for every source count and both completion modes;
- byte-lane coverage;
- the refusal cases;
- that a start is ignored while the engine is running.

// File: rtl/xzc_pkg.sv
package xzc_pkg;
  localparam int XZC_DW    = 64;
  localparam int XZC_LANES = XZC_DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FIN,
    ST_SUSP
  } xzc_state_e;

  // any byte lane of the combined word differs from 00h
  function automatic logic lanes_nonzero(input logic [XZC_DW-1:0] w);
    logic r;
    r = 1'b0;
    for (int i = 0; i < XZC_LANES; i++) begin
      r = r | (w[i*8 +: 8] != 8'h00);
    end
    return r;
  endfunction

  // non-zero multiple of the word size
  function automatic logic count_legal(input logic [31:0] c);
    return (c != 32'd0) && (c[2:0] == 3'd0);
  endfunction
endpackage

// File: rtl/xzc_cfg_check.sv
module xzc_cfg_check
  import xzc_pkg::*;
#(
  parameter int CW = 24,
  parameter int NS = 4,
  parameter int SW = 3
) (
  input  logic [CW-1:0] count,
  input  logic [SW-1:0] nsrc,
  input  logic [NS-1:0] src_local,
  output logic          ok
);
  logic [NS-1:0] remote_active;
  logic          nsrc_ok;

  for (genvar g = 0; g < NS; g++) begin : g_loc
    assign remote_active[g] = (SW'(g) < nsrc) && !src_local[g];
  end

  assign nsrc_ok = (nsrc >= SW'(2)) && (nsrc <= SW'(NS));
  assign ok      = count_legal(32'(count)) && nsrc_ok && (remote_active == '0);
endmodule

// File: rtl/xzc_addr_seq.sv
module xzc_addr_seq #(
  parameter int AW = 16,
  parameter int CW = 24,
  parameter int NS = 4,
  parameter int SW = 3,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          load,
  input  logic [NS*AW-1:0] base_flat,
  input  logic [SW-1:0] nsrc,
  input  logic [CW-1:0] count,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last_src,
  output logic          last_off
);
  logic [AW-1:0] base_q [NS];
  logic [IW-1:0] sidx;
  logic [CW-1:0] off;

  for (genvar g = 0; g < NS; g++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    base_q[g] <= '0;
      else if (load) base_q[g] <= base_flat[g*AW +: AW];
    end
  end

  assign last_src = ((SW'(sidx) + SW'(1)) == nsrc);
  assign last_off = ((off + CW'(8)) == count);
  assign addr     = base_q[sidx] + off[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sidx <= '0;
      off  <= '0;
    end else if (load) begin
      sidx <= '0;
      off  <= '0;
    end else if (step) begin
      if (last_src) begin
        sidx <= '0;
        off  <= off + CW'(8);
      end else begin
        sidx <= sidx + IW'(1);
      end
    end
  end

  // R2: the source index never reaches the active count during a pass
  assert_sidx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (SW'(sidx) < nsrc));
endmodule

// File: rtl/xzc_accum.sv
module xzc_accum
  import xzc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              load,
  input  logic              last,
  input  logic [XZC_DW-1:0] data,
  output logic              off_nz,
  output logic              nz
);
  logic [XZC_DW-1:0] acc;
  logic [XZC_DW-1:0] combined;

  assign combined = acc ^ data;
  assign off_nz   = load && last && lanes_nonzero(combined);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      nz  <= 1'b0;
    end else begin
      if (clr_all || (load && last)) acc <= '0;
      else if (load)                 acc <= combined;
      if (clr_all)                   nz  <= 1'b0;
      else if (off_nz)               nz  <= 1'b1;
    end
  end

  // R8: once set, the flag survives until the next accepted start
  assert_nz_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nz && !clr_all) |=> nz);
  // R1: the flag only rises on a non-zero offset result
  assert_nz_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!nz && !off_nz) |=> !nz);
endmodule

// File: rtl/xzc_engine.sv
module xzc_engine
  import xzc_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 24,
  parameter int NS = 4,
  localparam int SW   = $clog2(NS + 1),
  localparam int PADW = 30 - CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wb_en,
  input  logic [SW-1:0]     num_src,
  input  logic [CW-1:0]     byte_count,
  input  logic [NS*AW-1:0]  src_base,
  input  logic [NS-1:0]     src_local,
  input  logic              irq_ack,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_rvalid,
  input  logic [XZC_DW-1:0] rd_rdata,
  output logic              busy,
  output logic              cfg_err,
  output logic              stat_we,
  output logic [31:0]       stat_word,
  output logic              irq,
  output logic              res_nz
);
  xzc_state_e    state;
  logic [CW-1:0] count_q;
  logic [SW-1:0] nsrc_q;
  logic          wb_q;
  logic          cfg_err_q;

  logic cfg_ok, idle, accept, reject, beat, last_src, last_off, off_nz;

  assign idle   = (state == ST_IDLE);
  assign accept = start && idle && cfg_ok;
  assign reject = start && idle && !cfg_ok;
  assign beat   = (state == ST_WAIT) && rd_rvalid;

  xzc_cfg_check #(.CW(CW), .NS(NS), .SW(SW)) u_cfg (
    .count     (byte_count),
    .nsrc      (num_src),
    .src_local (src_local),
    .ok        (cfg_ok)
  );

  xzc_addr_seq #(.AW(AW), .CW(CW), .NS(NS), .SW(SW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .load      (accept),
    .base_flat (src_base),
    .nsrc      (nsrc_q),
    .count     (count_q),
    .step      (beat),
    .addr      (rd_addr),
    .last_src  (last_src),
    .last_off  (last_off)
  );

  xzc_accum u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (accept),
    .load    (beat),
    .last    (last_src),
    .data    (rd_rdata),
    .off_nz  (off_nz),
    .nz      (res_nz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      count_q   <= '0;
      nsrc_q    <= '0;
      wb_q      <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      cfg_err_q <= reject;
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_REQ;
          count_q <= byte_count;
          nsrc_q  <= num_src;
          wb_q    <= wb_en;
        end
        ST_REQ:  if (rd_ready) state <= ST_WAIT;
        ST_WAIT: if (rd_rvalid) state <= (last_src && last_off) ? ST_FIN : ST_REQ;
        ST_FIN:  state <= wb_q ? ST_IDLE : ST_SUSP;
        ST_SUSP: if (irq_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid  = (state == ST_REQ);
  assign busy      = !idle;
  assign cfg_err   = cfg_err_q;
  assign stat_we   = (state == ST_FIN) && wb_q;
  assign irq       = (state == ST_SUSP);
  assign stat_word = {1'b1, res_nz, {PADW{1'b0}}, count_q};

  // R3: a pending request holds its address until taken
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  // R3: no new request while a response is outstanding
  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_valid);
  // R4: a refusal never leaves the engine running
  assert_err_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);
  // R5: write-back and interrupt are exclusive
  assert_wb_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> (!irq && stat_word[31]));
  // R6: interrupt holds until acknowledged
  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  // R7: start has no effect while suspended
  assert_susp_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && start && !irq_ack) |=> (irq && !rd_valid));
endmodule

// File: tb/xzc_engine_tb.sv
module xzc_engine_tb;
  localparam int AW = 16;
  localparam int CW = 24;
  localparam int NS = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              wb_en = 1'b0;
  logic [2:0]        num_src = 3'd2;
  logic [CW-1:0]     byte_count = '0;
  logic [NS*AW-1:0]  src_base = {16'h0600, 16'h0400, 16'h0200, 16'h0000};
  logic [NS-1:0]     src_local = 4'hF;
  logic              irq_ack = 1'b0;
  logic              rd_valid, rd_ready = 1'b0;
  logic [AW-1:0]     rd_addr;
  logic              rd_rvalid = 1'b0;
  logic [63:0]       rd_rdata = '0;
  logic              busy, cfg_err, stat_we, irq, res_nz;
  logic [31:0]       stat_word;

  xzc_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wb_en(wb_en), .num_src(num_src),
    .byte_count(byte_count), .src_base(src_base), .src_local(src_local),
    .irq_ack(irq_ack), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .busy(busy), .cfg_err(cfg_err),
    .stat_we(stat_we), .stat_word(stat_word), .irq(irq), .res_nz(res_nz)
  );

  logic [63:0]   mem  [0:255];
  logic [AW-1:0] alog [0:255];
  int nlog = 0;
  int cyc = 0;
  int pcnt = 0;
  logic [AW-1:0] paddr = '0;
  int errors = 0;
  int checks = 0;

  // memory model: two-cycle response latency, one request at a time
  always @(posedge clk) begin
    cyc = cyc + 1;
    rd_rvalid <= 1'b0;
    if (pcnt == 1) begin
      rd_rvalid <= 1'b1;
      rd_rdata  <= mem[paddr[10:3]];
    end
    if (pcnt > 0) pcnt = pcnt - 1;
    if (rd_valid && rd_ready) begin
      pcnt  = 2;
      paddr = rd_addr;
      if (nlog < 256) alog[nlog] = rd_addr;
      nlog = nlog + 1;
    end
  end

  always @(negedge clk) rd_ready <= ((cyc % 3) != 2);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] hv(input int a);
    logic [63:0] x;
    x = 64'h9E3779B97F4A7C15 * 64'(a + 1);
    return x ^ (x >> 29);
  endfunction

  // sources 0..n-2 random, source n-1 makes the XOR zero, unused ones junk
  task automatic fill(input int n, input int cnt, input int seed,
                      input int flip_w, input int flip_b);
    for (int w = 0; w < cnt / 8; w++) begin
      logic [63:0] x;
      x = '0;
      for (int s = 0; s < NS; s++) begin
        if (s != n - 1) begin
          mem[s*64 + w] = hv(seed * 1000 + s * 97 + w);
          if (s < n - 1) x = x ^ mem[s*64 + w];
        end
      end
      mem[(n-1)*64 + w] = x;
      if (w == flip_w) mem[(n-1)*64 + w] = x ^ (64'h1 << (8 * flip_b + (flip_b % 8)));
    end
  endtask

  function automatic bit exp_nz(input int n, input int cnt);
    for (int w = 0; w < cnt / 8; w++) begin
      logic [63:0] x;
      x = '0;
      for (int s = 0; s < n; s++) x = x ^ mem[s*64 + w];
      if (x != 0) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic run(input int n, input int cnt, input bit wb, input logic [3:0] loc,
                     input bit midstart, input string tag);
    bit e;
    int t;
    int bad;
    int nl;
    e = exp_nz(n, cnt);
    @(negedge clk);
    num_src = 3'(n); byte_count = CW'(cnt); wb_en = wb; src_local = loc;
    nlog = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!(stat_we || irq) && t < 20000) begin
      if (midstart && t == 20) begin start = 1'b1; byte_count = CW'(8); num_src = 3'd2; end
      else start = 1'b0;
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    if (t >= 20000) begin
      chk(1'b0, {tag, " watchdog"}, t, 0);
      return;
    end
    if (wb) begin
      chk(stat_we && stat_word[31] && !irq, {tag, " R5 complete strobe"}, stat_word, 32'h8000_0000);
      chk(stat_word[30] == e, {tag, " R1 R5 not-zero bit"}, stat_word[30], e);
      chk(stat_word[23:0] == cnt[23:0], {tag, " R5 count field"}, stat_word[23:0], cnt);
      @(negedge clk);
      chk(!busy && !stat_we, {tag, " R5 back to idle"}, busy, 0);
    end else begin
      chk(irq && !stat_we, {tag, " R6 interrupt"}, irq, 1);
      chk(res_nz == e, {tag, " R1 R6 result"}, res_nz, e);
      nl = nlog;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      chk(irq && busy && nlog == nl, {tag, " R6 R7 held while suspended"}, nlog, nl);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk(!busy && !irq, {tag, " R6 idle after ack"}, busy, 0);
      @(negedge clk);
      chk(!busy, {tag, " R7 no restart"}, busy, 0);
    end
    chk(nlog == n * cnt / 8, {tag, " R2 R7 read count"}, nlog, n * cnt / 8);
    bad = 0;
    for (int i = 0; i < nlog && i < 256; i++) begin
      if (alog[i] != AW'((i % n) * 512 + (i / n) * 8)) bad++;
    end
    chk(bad == 0, {tag, " R2 R3 address order"}, bad, 0);
  endtask

  task automatic err_case(input int n, input int cnt, input logic [3:0] loc, input string tag);
    @(negedge clk);
    num_src = 3'(n); byte_count = CW'(cnt); src_local = loc; wb_en = 1'b1;
    nlog = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err && !busy, {tag, " R4 refusal pulse"}, cfg_err, 1);
    @(negedge clk);
    chk(!cfg_err && !busy, {tag, " R4 pulse ends"}, cfg_err, 0);
    repeat (4) @(negedge clk);
    chk(nlog == 0 && !busy, {tag, " R4 no reads"}, nlog, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !rd_valid && !stat_we && !cfg_err && !res_nz,
        "reset R3 R5 R6 outputs low", {busy, irq, rd_valid, stat_we, cfg_err, res_nz}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 2; n <= 4; n++) begin
      for (int wb = 0; wb < 2; wb++) begin
        fill(n, 256, n * 10 + wb, 31, n + wb);
        run(n, 256, 1'(wb), 4'hF, 1'b0, "R1 dirty");
        fill(n, 256, n * 10 + wb + 5, -1, 0);
        run(n, 256, 1'(wb), 4'hF, 1'b0, "R8 clean after dirty");
      end
    end

    for (int b = 0; b < 8; b++) begin
      fill(3, 16, 50 + b, 1, b);
      run(3, 16, 1'b1, 4'hF, 1'b0, "R9 byte lane");
    end

    fill(4, 64, 77, 3, 2);
    run(4, 64, 1'b1, 4'hF, 1'b1, "R7 start while running");

    fill(2, 32, 88, -1, 0);
    run(2, 32, 1'b1, 4'b0011, 1'b0, "R10 unused remote ignored");

    err_case(3, 0, 4'hF, "R4 zero count");
    err_case(3, 12, 4'hF, "R4 unaligned count");
    err_case(1, 64, 4'hF, "R4 one source");
    err_case(5, 64, 4'hF, "R4 five sources");
    err_case(3, 64, 4'b1011, "R4 remote active source");

    fill(2, 8, 99, 0, 7);
    run(2, 8, 1'b0, 4'hF, 1'b0, "R1 single word");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule